// File: doc/BRIEF.md
# Buffered PWM Control and Bank Disable

This block sits next to a multi-channel motor-control PWM counter and owns the settings that counter runs with. Software writes a control byte that holds a counter clock divide, a reload rate and three correction-polarity bits. The counter never reads the written byte directly. Each field is moved into an active copy only at its own safe moment, so a period never runs with a half-changed setting. A prescaler change waits for a load-ok request and then for the next PWM cycle start. The polarity bits are refreshed at every cycle start while software correction is selected. A reload-rate change waits until the running load cycle has ended.

The block also gates six raw PWM outputs. Each of the two output banks has a software disable bit. A write-once mask register picks which outputs of each bank the disable bit may force low. Clearing a disable bit does not release the outputs at once. They come back at the next PWM cycle start.

A second read port shows the active values, so the values the counter really uses can be observed.

Top module: `pwmc_buffered_ctrl`

Each bank runs a small state machine with three states:
- `B_RUN`: outputs pass.
- `B_OFF`: the disable bit is set.
- `B_WAIT`: the bit is cleared and the bank waits for a cycle start.

Its transitions are:
- `B_RUN` to `B_OFF` when the bit is set.
- `B_OFF` to `B_WAIT` when the bit is cleared with no cycle start.
- `B_OFF` to `B_RUN` when the bit is cleared in a cycle-start cycle.
- `B_WAIT` to `B_OFF` when the bit is set again.
- `B_WAIT` to `B_RUN` on a cycle start.

The mask register has two states:
- `M_OPEN`, the reset state.
- `M_LOCKED`, entered on the first mask write.

The load-ok flag has two states:
- `LD_IDLE` goes to `LD_ARMED` on `ldok_set`.
- `LD_ARMED` goes back to `LD_IDLE` when the prescaler is committed.

## Requirements
- R1: After reset every register and every active value is 0. Both banks are in `B_RUN` and `pwm_out` equals `pwm_in`.
- R2: The control register sits at address 0 and uses these fields:
  - bits 6:5 are the reload-rate code;
  - bits 4:2 are the polarity bits;
  - bits 1:0 are the prescaler code;
  - bit 7 always reads 0.

  Reads return the written value, not the active copy.
- R3: The active prescaler takes the written code only at a cycle start while the load-ok flag is set. The flag is set by `ldok_set` and clears itself at that commit. If `ldok_set` falls in the commit cycle, the flag stays set.
- R4: The active polarity bits take the written bits at every cycle start while `sw_corr` is 1. At other times they hold.
- R5: Codes 0, 1, 2 and 3 of the reload rate give a load cycle of 1, 2, 4 or 8 cycle starts. The active code changes only at the cycle start that ends the running load cycle.
- R6: The disable register sits at address 1, with bit 0 for bank X and bit 1 for bank Y. Bank X is outputs 0 to 3 and bank Y is outputs 4 and 5. While a bank's bit is set, its outputs whose mask bit is 1 are driven 0. All other outputs follow `pwm_in`.
- R7: After a disable bit is cleared, the forced outputs stay 0 until the next cycle start. They follow `pwm_in` from the clock edge of that cycle start.
- R8: The mask register sits at address 2, with bit i for output i. The first write after reset is stored. Every later write is ignored.
- R9: `stat_rdata` shows the active values and the flag:
  - bit 7 is the load-ok flag;
  - bits 6:5 are the active reload-rate code;
  - bits 4:2 are the active polarity bits;
  - bits 1:0 are the active prescaler code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cycle_start | input | 1 | One-clock strobe at each PWM cycle start |
| ldok_set | input | 1 | Requests a prescaler load |
| sw_corr | input | 1 | Software correction mode selected |
| pwm_in | input | 6 | Raw PWM outputs |
| pwm_out | output | 6 | Gated PWM outputs |
| act_prsc | output | 2 | Active prescaler code |
| act_ldfq | output | 2 | Active reload-rate code |
| act_pol | output | 3 | Active polarity bits |
| stat_rdata | output | 8 | Status view of active values |

## Verification
The assertions check on every cycle that each active field changes only in a cycle it may change in. They check that the load-ok flag drops after a commit and that a locked mask never moves. They also check that a bank leaves its forced state only at a cycle start and that a masked, disabled output is low. Only the bench's scenarios can show that the right values arrive: the committed codes, the exact count of cycle starts in a load cycle, the selection of outputs by the mask in each bank, and the read-back of written rather than active values.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIS  = 2'd1;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd2;

    typedef enum logic [1:0] {B_RUN, B_OFF, B_WAIT} bank_st_t;
    typedef enum logic {M_OPEN, M_LOCKED} mask_st_t;
    typedef enum logic {LD_IDLE, LD_ARMED} ldok_st_t;

    typedef struct packed {
        logic [1:0] ldfq;
        logic [2:0] pol;
        logic [1:0] prsc;
    } ctrl_t;

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int NUM_OUT  = 6,
    parameter int NUM_BANK = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output ctrl_t               ctrl,
    output logic [NUM_BANK-1:0] dis,
    output logic [NUM_OUT-1:0]  mask
);

    logic [7:0] ctrl_q;
    mask_st_t   mst_q, mst_d;

    // Register state: control and disable bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dis    <= '0;
        end else if (wr) begin
            if (addr == A_CTRL) ctrl_q <= wdata & 8'h7F;
            if (addr == A_DIS)  dis    <= wdata[NUM_BANK-1:0];
        end
    end

    // Write-once mask: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mst_q <= M_OPEN;
        else        mst_q <= mst_d;
    end

    always_comb begin
        mst_d = mst_q;
        unique case (mst_q)
            M_OPEN:   if (wr && addr == A_MASK) mst_d = M_LOCKED;
            M_LOCKED: mst_d = M_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     mask <= '0;
        else if (mst_q == M_OPEN && wr && addr == A_MASK) mask <= wdata[NUM_OUT-1:0];
    end

    assign ctrl = ctrl_t'(ctrl_q[6:0]);

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_DIS:   rdata[NUM_BANK-1:0] = dis;
            A_MASK:  rdata[NUM_OUT-1:0]  = mask;
            default: rdata = '0;
        endcase
    end

    // R8
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_q == M_LOCKED) |=> $stable(mask));

endmodule

// File: rtl/pwmc_commit.sv
module pwmc_commit
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cycle_start,
    input  logic       ldok_set,
    input  logic       sw_corr,
    input  ctrl_t      ctrl,
    output logic [1:0] act_prsc,
    output logic [2:0] act_pol,
    output logic [1:0] act_ldfq,
    output logic       ldok
);

    ldok_st_t   ld_q, ld_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic       commit_prsc;
    logic       load_end;

    // Load-ok flag: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= LD_IDLE;
        else        ld_q <= ld_d;
    end

    always_comb begin
        ld_d = ld_q;
        unique case (ld_q)
            LD_IDLE:  if (ldok_set) ld_d = LD_ARMED;
            LD_ARMED: if (cycle_start && !ldok_set) ld_d = LD_IDLE;
        endcase
    end

    assign ldok        = (ld_q == LD_ARMED);
    assign commit_prsc = cycle_start && ldok;

    // Last count value of a load cycle: 2**code - 1
    always_comb begin
        unique case (act_ldfq)
            2'd0: last_cnt = CNT_W'(0);
            2'd1: last_cnt = CNT_W'(1);
            2'd2: last_cnt = CNT_W'(3);
            2'd3: last_cnt = CNT_W'(7);
        endcase
    end

    assign load_end = cycle_start && (cnt_q == last_cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            act_ldfq <= '0;
            act_prsc <= '0;
            act_pol  <= '0;
        end else begin
            if (load_end) begin
                cnt_q    <= '0;
                act_ldfq <= ctrl.ldfq;
            end else if (cycle_start) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (commit_prsc)             act_prsc <= ctrl.prsc;
            if (cycle_start && sw_corr)  act_pol  <= ctrl.pol;
        end
    end

    // R3
    prsc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cycle_start && ldok) |=> $stable(act_prsc));
    // R3
    ldok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && ldok && !ldok_set) |=> !ldok);
    // R4
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cycle_start && sw_corr) |=> $stable(act_pol));
    // R5
    ldfq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(act_ldfq));

endmodule

// File: rtl/pwmc_bank_gate.sv
module pwmc_bank_gate
    import pwmc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dis,
    input  logic cycle_start,
    output logic force_off
);

    bank_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= B_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            B_RUN:  if (dis) st_d = B_OFF;
            B_OFF:  if (!dis) st_d = cycle_start ? B_RUN : B_WAIT;
            B_WAIT: if (dis) st_d = B_OFF;
                    else if (cycle_start) st_d = B_RUN;
            default: st_d = B_RUN;
        endcase
    end

    // Output process
    always_comb begin
        force_off = dis || (st_q != B_RUN);
    end

    // R7
    release_at_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != B_RUN && !cycle_start) |=> (st_q != B_RUN));

endmodule

// File: rtl/pwmc_buffered_ctrl.sv
module pwmc_buffered_ctrl
    import pwmc_pkg::*;
#(
    parameter int NUM_X = 4,
    parameter int NUM_Y = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cycle_start,
    input  logic       ldok_set,
    input  logic       sw_corr,
    input  logic [5:0] pwm_in,
    output logic [5:0] pwm_out,
    output logic [1:0] act_prsc,
    output logic [1:0] act_ldfq,
    output logic [2:0] act_pol,
    output logic [7:0] stat_rdata
);

    localparam int NUM_OUT  = NUM_X + NUM_Y;
    localparam int NUM_BANK = 2;

    ctrl_t               ctrl;
    logic [NUM_BANK-1:0] dis;
    logic [NUM_OUT-1:0]  mask;
    logic [NUM_BANK-1:0] force_off;
    logic                ldok;

    pwmc_regs #(.NUM_OUT(NUM_OUT), .NUM_BANK(NUM_BANK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl),
        .dis(dis), .mask(mask)
    );

    pwmc_commit #(.CNT_W(3)) u_commit (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
        .ldok_set(ldok_set), .sw_corr(sw_corr), .ctrl(ctrl),
        .act_prsc(act_prsc), .act_pol(act_pol), .act_ldfq(act_ldfq),
        .ldok(ldok)
    );

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        pwmc_bank_gate u_gate (
            .clk(clk), .rst_n(rst_n), .dis(dis[b]),
            .cycle_start(cycle_start), .force_off(force_off[b])
        );
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        localparam int BANK = (i < NUM_X) ? 0 : 1;
        assign pwm_out[i] = pwm_in[i] & ~(mask[i] & force_off[BANK]);
    end

    assign stat_rdata = {ldok, act_ldfq, act_pol, act_prsc};

    // R6
    x_forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis[0] && mask[0]) |-> !pwm_out[0]);
    // R6
    y_forced_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis[1] && mask[NUM_X]) |-> !pwm_out[NUM_X]);

endmodule

// File: tb/test_pwmc_buffered_ctrl.sv
module test_pwmc_buffered_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cycle_start = 1'b0;
    logic       ldok_set = 1'b0;
    logic       sw_corr = 1'b0;
    logic [5:0] pwm_in = '0;
    logic [5:0] pwm_out;
    logic [1:0] act_prsc;
    logic [1:0] act_ldfq;
    logic [2:0] act_pol;
    logic [7:0] stat_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwmc_buffered_ctrl i_pwmc_buffered_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cycle_start(cycle_start),
        .ldok_set(ldok_set), .sw_corr(sw_corr), .pwm_in(pwm_in), .pwm_out(pwm_out),
        .act_prsc(act_prsc), .act_ldfq(act_ldfq), .act_pol(act_pol),
        .stat_rdata(stat_rdata)
    );

    // [15:8] ctrl byte, [7] ldok, [6] sw_corr, [5:4] exp prsc, [3:1] exp pol
    localparam logic [15:0] VEC [0:5] = '{
        16'h0DD6, 16'h1258, 16'h1FB8, 16'h00C0, 16'h0A00, 16'h0AE4
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_cs();
        @(negedge clk);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
    endtask

    task automatic pulse_ldok();
        @(negedge clk);
        ldok_set = 1'b1;
        @(negedge clk);
        ldok_set = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pwm_in = 6'h2D;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out", {2'b0, pwm_out}, 8'h2D);
        check("R1 stat", stat_rdata, 8'h00);
        bus_addr = 2'd0; #1;
        check("R1 ctrl", bus_rdata, 8'h00);

        // Vector table: R2 R3 R4 R9
        for (int k = 0; k < 6; k++) begin
            write(2'd0, VEC[k][15:8]);
            if (VEC[k][7]) begin
                pulse_ldok();
                check("R3 ldok armed", {7'b0, stat_rdata[7]}, 8'h01);
            end
            sw_corr = VEC[k][6];
            pulse_cs();
            check("R3 prsc", {6'b0, act_prsc}, {6'b0, VEC[k][5:4]});
            check("R4 pol", {5'b0, act_pol}, {5'b0, VEC[k][3:1]});
            check("R9 stat", stat_rdata, {1'b0, 2'b00, VEC[k][3:1], VEC[k][5:4]});
            bus_addr = 2'd0; #1;
            check("R2 readback", bus_rdata, VEC[k][15:8] & 8'h7F);
        end
        sw_corr = 1'b0;

        // R2 bit 7 reads 0; reads show written value, not active
        write(2'd0, 8'hFF);
        bus_addr = 2'd0; #1;
        check("R2 bit7", bus_rdata, 8'h7F);
        check("R2 not active", {6'b0, act_prsc}, 8'h02);

        // R5 load-frequency commit
        write(2'd0, 8'h40);
        pulse_cs();
        check("R5 first commit", {6'b0, act_ldfq}, 8'h02);
        write(2'd0, 8'h20);
        for (int k = 0; k < 3; k++) begin
            pulse_cs();
            check("R5 hold in load cycle", {6'b0, act_ldfq}, 8'h02);
        end
        pulse_cs();
        check("R5 commit at end", {6'b0, act_ldfq}, 8'h01);
        pulse_cs();
        check("R5 period two hold", {6'b0, act_ldfq}, 8'h01);

        // R8 mask write-once, R6 bank X
        do_reset();
        pwm_in = 6'h3F;
        write(2'd2, 8'h05);
        write(2'd2, 8'h3F);
        bus_addr = 2'd2; #1;
        check("R8 mask locked", bus_rdata, 8'h05);
        write(2'd1, 8'h01);
        check("R6 bank X", {2'b0, pwm_out}, 8'h3A);
        write(2'd1, 8'h03);
        check("R6 bank Y unmasked", {2'b0, pwm_out}, 8'h3A);
        // R7 delayed release
        write(2'd1, 8'h00);
        check("R7 still forced", {2'b0, pwm_out}, 8'h3A);
        repeat (3) @(negedge clk);
        check("R7 still forced later", {2'b0, pwm_out}, 8'h3A);
        pulse_cs();
        check("R7 released", {2'b0, pwm_out}, 8'h3F);

        // R6 bank Y with a fresh mask
        do_reset();
        write(2'd2, 8'h30);
        write(2'd1, 8'h02);
        check("R6 bank Y", {2'b0, pwm_out}, 8'h0F);
        write(2'd1, 8'h01);
        check("R6 bank X unmasked", {2'b0, pwm_out}, 8'h0F);
        write(2'd1, 8'h00);
        pulse_cs();
        check("R7 Y released", {2'b0, pwm_out}, 8'h3F);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule